// File: doc/BRIEF.md
# Overlay Paging Control and Address Decoder

This block controls how a small external memory board overlays the lowest 16K of a host CPU's address space. Software writes one 8-bit control byte. That byte holds a force bit, a sticky lock bit and a 2-bit RAM bank number. For each memory access, the block combines that state with a "mapped" flag from a separate pager and with a write-protect strap. From these it chooses what answers the access: the host's own ROM, the overlay ROM/EEPROM, or one of four 8K RAM banks. It also decides whether a write may reach that device.

The force bit maps the overlay at once, whatever the pager says. The lock bit changes the mapped layout so that RAM bank 3 stands in for the overlay ROM and is write protected everywhere. Once the lock bit is set, only a power-on reset can clear it. An ordinary reset clears only the force bit and the bank field. All outputs are combinational from the address, the strobes, the pager flag and the registered control state.

Top module: `overlay_map_ctrl`

## Requirements
- R1: After power-on reset (`por_ni` low), the force bit, the lock bit and the bank field are all 0. With the pager flag high, the low 8K selects the overlay ROM and `ram_bank_o` reads 0.
- R2: A control write takes effect at the next rising clock edge. Data bit 7 sets the force bit, bit 6 sets the lock bit and bits 1..0 set the bank number. Bits 5..2 have no effect.
- R3: Writing 0 to bit 6 never clears a set lock bit. The mapped low 8K keeps selecting RAM bank 3 after such a write.
- R4: Ordinary reset (`rst_ni` low) clears the force bit and the bank field, and leaves the lock bit unchanged.
- R5: With the force bit set, region 0000h-1FFFh (address bits 15..13 = 000) selects the overlay ROM. Region 2000h-3FFFh (address bits 15..13 = 001) selects the RAM bank in the bank field. This holds for any value of the pager flag and the lock bit.
- R6: With the force bit set, RAM writes are always enabled. Overlay ROM writes are enabled only while `wp_strap_i` is 0.
- R7: With force clear, lock clear and the pager flag high, the overlay ROM answers in the low 8K and is never writable. The selected RAM bank answers in the upper 8K and is writable, including bank 3.
- R8: With force clear, lock set and the pager flag high, the low 8K selects RAM with `ram_bank_o` = 3 and no write enable. The upper 8K selects the bank in the bank field and is writable unless that bank is 3.
- R9: With force clear and the pager flag low, no overlay chip select is asserted and `host_rom_dis_o` stays 0.
- R10: Addresses with bits 15..14 not both 0 (4000h and up) never assert any overlay chip select, write enable or `host_rom_dis_o`.
- R11: `host_rom_dis_o` is 1 exactly when the address is below 4000h and the force bit or the pager flag is set, independent of the strobes.
- R12: Chip selects are asserted only while `mem_rd_i` or `mem_wr_i` is high. Write enables are asserted only while `mem_wr_i` is high. `ram_bank_o` shows 3 when the lock bit is set, force is clear and the address is in the low 8K. Otherwise it shows the bank field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous; clears every control bit |
| rst_ni | input | 1 | Ordinary reset, active low, asynchronous; keeps the lock bit |
| addr_i | input | 3 | CPU address bits 15..13 |
| mem_rd_i | input | 1 | Memory read strobe |
| mem_wr_i | input | 1 | Memory write strobe |
| cfg_wr_i | input | 1 | Control register write strobe |
| cfg_data_i | input | 8 | Control register write data |
| mapped_i | input | 1 | Overlay mapped flag from the pager |
| wp_strap_i | input | 1 | Write-protect strap; 1 protects the overlay ROM |
| host_rom_dis_o | output | 1 | Disables the host ROM while the overlay owns the access |
| ovl_rom_cs_o | output | 1 | Overlay ROM/EEPROM chip select |
| ram_cs_o | output | 1 | Overlay RAM chip select |
| ram_bank_o | output | 2 | RAM bank number for the current access |
| ovl_rom_we_o | output | 1 | Overlay ROM/EEPROM write enable |
| ram_we_o | output | 1 | Overlay RAM write enable |

## Verification
The assertions check invariants on every cycle. The lock bit never falls outside power-on reset, and an ordinary reset leaves the force bit clear. The two chip selects never fire together, and no select or host-ROM disable appears at 4000h or above. Write enables need the write strobe, the ROM write enable needs the strap absent, and bank 3 is never written in the locked mapped layout. Only the bench scenarios can show the full decode matrix, the effect of each control field and the ignored reserved bits. They also show that the lock survives both a write of zero and an ordinary reset, and that power-on clears it.

// File: rtl/ovl_map_pkg.sv
package ovl_map_pkg;
  typedef enum logic [1:0] {
    RGN_LOW  = 2'd0,
    RGN_HIGH = 2'd1,
    RGN_OUT  = 2'd2
  } rgn_e;
endpackage

// File: rtl/ovl_cfg_reg.sv
module ovl_cfg_reg #(
  parameter int unsigned CFG_W      = 8,
  parameter int unsigned BANK_W     = 2,
  parameter int unsigned FORCE_BIT  = 7,
  parameter int unsigned STICKY_BIT = 6
) (
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CFG_W-1:0]  data_i,
  output logic              force_o,
  output logic              sticky_o,
  output logic [BANK_W-1:0] bank_o
);
  logic unused_rsvd;
  assign unused_rsvd = ^data_i;

  // lock bit: set-only, cleared by power-on alone
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)   sticky_o <= 1'b0;
    else if (wr_i) sticky_o <= sticky_o | data_i[STICKY_BIT];
  end

  always_ff @(posedge clk_i or negedge por_ni or negedge rst_ni) begin
    if (!por_ni || !rst_ni) begin
      force_o <= 1'b0;
      bank_o  <= '0;
    end else if (wr_i) begin
      force_o <= data_i[FORCE_BIT];
      bank_o  <= data_i[BANK_W-1:0];
    end
  end
endmodule

// File: rtl/ovl_region_decode.sv
module ovl_region_decode #(
  parameter int unsigned HI_W = 3
) (
  input  logic [HI_W-1:0]        addr_i,
  output ovl_map_pkg::rgn_e      rgn_o
);
  localparam logic [HI_W-1:0] LOW_SLOT  = '0;
  localparam logic [HI_W-1:0] HIGH_SLOT = {{(HI_W-1){1'b0}}, 1'b1};

  always_comb begin
    if (addr_i == LOW_SLOT)       rgn_o = ovl_map_pkg::RGN_LOW;
    else if (addr_i == HIGH_SLOT) rgn_o = ovl_map_pkg::RGN_HIGH;
    else                          rgn_o = ovl_map_pkg::RGN_OUT;
  end
endmodule

// File: rtl/ovl_select_mux.sv
module ovl_select_mux #(
  parameter int unsigned BANK_W = 2
) (
  input  ovl_map_pkg::rgn_e  rgn_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic               force_i,
  input  logic               sticky_i,
  input  logic               mapped_i,
  input  logic               wp_i,
  input  logic [BANK_W-1:0]  bank_i,
  output logic               host_dis_o,
  output logic               rom_cs_o,
  output logic               ram_cs_o,
  output logic [BANK_W-1:0]  bank_o,
  output logic               rom_we_o,
  output logic               ram_we_o
);
  import ovl_map_pkg::*;

  localparam logic [BANK_W-1:0] PROT_BANK = '1;

  logic strb;
  logic active;
  assign strb   = rd_i | wr_i;
  assign active = force_i | mapped_i;

  always_comb begin
    host_dis_o = active & (rgn_i != RGN_OUT);
    rom_cs_o   = 1'b0;
    ram_cs_o   = 1'b0;
    rom_we_o   = 1'b0;
    ram_we_o   = 1'b0;
    bank_o     = (rgn_i == RGN_LOW && sticky_i && !force_i) ? PROT_BANK : bank_i;
    if (active) begin
      unique case (rgn_i)
        RGN_LOW: begin
          if (force_i) begin
            rom_cs_o = strb;
            rom_we_o = wr_i & ~wp_i;
          end else if (sticky_i) begin
            ram_cs_o = strb;
          end else begin
            rom_cs_o = strb;
          end
        end
        RGN_HIGH: begin
          ram_cs_o = strb;
          ram_we_o = wr_i & (force_i | ~sticky_i | (bank_i != PROT_BANK));
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/overlay_map_ctrl.sv
module overlay_map_ctrl #(
  parameter int unsigned CFG_W      = 8,
  parameter int unsigned BANK_W     = 2,
  parameter int unsigned HI_W       = 3,
  parameter int unsigned FORCE_BIT  = CFG_W - 1,
  parameter int unsigned STICKY_BIT = CFG_W - 2
) (
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              rst_ni,
  input  logic [HI_W-1:0]   addr_i,
  input  logic              mem_rd_i,
  input  logic              mem_wr_i,
  input  logic              cfg_wr_i,
  input  logic [CFG_W-1:0]  cfg_data_i,
  input  logic              mapped_i,
  input  logic              wp_strap_i,
  output logic              host_rom_dis_o,
  output logic              ovl_rom_cs_o,
  output logic              ram_cs_o,
  output logic [BANK_W-1:0] ram_bank_o,
  output logic              ovl_rom_we_o,
  output logic              ram_we_o
);
  logic              force_q;
  logic              sticky_q;
  logic [BANK_W-1:0] bank_q;
  ovl_map_pkg::rgn_e rgn;

  ovl_cfg_reg #(
    .CFG_W(CFG_W), .BANK_W(BANK_W), .FORCE_BIT(FORCE_BIT), .STICKY_BIT(STICKY_BIT)
  ) u_cfg (
    .clk_i   (clk_i),
    .por_ni  (por_ni),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_wr_i),
    .data_i  (cfg_data_i),
    .force_o (force_q),
    .sticky_o(sticky_q),
    .bank_o  (bank_q)
  );

  ovl_region_decode #(.HI_W(HI_W)) u_rgn (
    .addr_i(addr_i),
    .rgn_o (rgn)
  );

  ovl_select_mux #(.BANK_W(BANK_W)) u_sel (
    .rgn_i     (rgn),
    .rd_i      (mem_rd_i),
    .wr_i      (mem_wr_i),
    .force_i   (force_q),
    .sticky_i  (sticky_q),
    .mapped_i  (mapped_i),
    .wp_i      (wp_strap_i),
    .bank_i    (bank_q),
    .host_dis_o(host_rom_dis_o),
    .rom_cs_o  (ovl_rom_cs_o),
    .ram_cs_o  (ram_cs_o),
    .bank_o    (ram_bank_o),
    .rom_we_o  (ovl_rom_we_o),
    .ram_we_o  (ram_we_o)
  );
endmodule

// File: rtl/ovl_map_chk.sv
module ovl_map_chk #(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned HI_W   = 3
) (
  input logic              clk_i,
  input logic              por_ni,
  input logic              rst_ni,
  input logic [HI_W-1:0]   addr_i,
  input logic              mem_wr_i,
  input logic              wp_strap_i,
  input logic              force_q,
  input logic              sticky_q,
  input logic              host_rom_dis_o,
  input logic              ovl_rom_cs_o,
  input logic              ram_cs_o,
  input logic [BANK_W-1:0] ram_bank_o,
  input logic              ovl_rom_we_o,
  input logic              ram_we_o
);
  localparam logic [BANK_W-1:0] PROT_BANK = '1;

  logic above;
  assign above = (addr_i[HI_W-1 -: 2] != 2'b00);

  assert_sticky_hold_R3: assert property (@(posedge clk_i) disable iff (!por_ni)
    sticky_q |=> sticky_q);

  assert_rst_clears_force_R4: assert property (@(posedge clk_i) disable iff (!por_ni)
    !rst_ni |-> !force_q);

  assert_no_dual_select_R12: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    !(ovl_rom_cs_o && ram_cs_o));

  assert_quiet_above_R10: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    above |-> !(ovl_rom_cs_o || ram_cs_o || host_rom_dis_o || ovl_rom_we_o || ram_we_o));

  assert_select_disables_host_R11: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (ovl_rom_cs_o || ram_cs_o) |-> host_rom_dis_o);

  assert_we_needs_strobe_R12: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (ram_we_o || ovl_rom_we_o) |-> mem_wr_i);

  assert_rom_we_strap_R6: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    ovl_rom_we_o |-> (!wp_strap_i && force_q && ovl_rom_cs_o));

  assert_prot_bank_ro_R8: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (ram_we_o && sticky_q && !force_q) |-> (ram_bank_o != PROT_BANK));
endmodule

bind overlay_map_ctrl ovl_map_chk #(.BANK_W(BANK_W), .HI_W(HI_W)) u_chk (
  .clk_i         (clk_i),
  .por_ni        (por_ni),
  .rst_ni        (rst_ni),
  .addr_i        (addr_i),
  .mem_wr_i      (mem_wr_i),
  .wp_strap_i    (wp_strap_i),
  .force_q       (force_q),
  .sticky_q      (sticky_q),
  .host_rom_dis_o(host_rom_dis_o),
  .ovl_rom_cs_o  (ovl_rom_cs_o),
  .ram_cs_o      (ram_cs_o),
  .ram_bank_o    (ram_bank_o),
  .ovl_rom_we_o  (ovl_rom_we_o),
  .ram_we_o      (ram_we_o)
);

// File: tb/overlay_map_ctrl_tb_top.sv
`timescale 1ns/1ps
module overlay_map_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       rst_n = 1'b1;
  logic [2:0] addr = '0;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_data = '0;
  logic       mapped = 1'b0;
  logic       wp = 1'b1;
  logic       dis, rom_cs, ram_cs, rom_we, ram_we;
  logic [1:0] bank;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  overlay_map_ctrl dut_i (
    .clk_i(clk), .por_ni(por_n), .rst_ni(rst_n), .addr_i(addr),
    .mem_rd_i(rd), .mem_wr_i(wr), .cfg_wr_i(cfg_wr), .cfg_data_i(cfg_data),
    .mapped_i(mapped), .wp_strap_i(wp), .host_rom_dis_o(dis),
    .ovl_rom_cs_o(rom_cs), .ram_cs_o(ram_cs), .ram_bank_o(bank),
    .ovl_rom_we_o(rom_we), .ram_we_o(ram_we)
  );

  // result = {dis, rom_cs, ram_cs, bank[1:0], rom_we, ram_we}
  typedef struct packed {
    logic [7:0] cfg;
    logic       map;
    logic       wp;
    logic [2:0] a;
    logic       r;
    logic       w;
    logic [6:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 1'b0, 1'b1, 3'b000, 1'b1, 1'b0, 7'b0000000, 4'd9 },  // R9
    '{8'h00, 1'b1, 1'b1, 3'b000, 1'b1, 1'b0, 7'b1100000, 4'd7 },  // R7
    '{8'h00, 1'b1, 1'b0, 3'b000, 1'b0, 1'b1, 7'b1100000, 4'd7 },  // R7 rom read-only
    '{8'h02, 1'b1, 1'b1, 3'b001, 1'b0, 1'b1, 7'b1011001, 4'd7 },  // R7
    '{8'h03, 1'b1, 1'b1, 3'b001, 1'b0, 1'b1, 7'b1011101, 4'd7 },  // R7 bank 3 writable
    '{8'h3D, 1'b1, 1'b1, 3'b001, 1'b1, 1'b0, 7'b1010100, 4'd2 },  // R2 reserved ignored
    '{8'h81, 1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 7'b1100110, 4'd6 },  // R6 strap absent
    '{8'h81, 1'b0, 1'b1, 3'b000, 1'b0, 1'b1, 7'b1100100, 4'd6 },  // R6 strap present
    '{8'h83, 1'b0, 1'b1, 3'b001, 1'b0, 1'b1, 7'b1011101, 4'd6 },  // R6 ram always
    '{8'h82, 1'b0, 1'b1, 3'b010, 1'b1, 1'b0, 7'b0001000, 4'd10},  // R10
    '{8'h00, 1'b1, 1'b1, 3'b111, 1'b0, 1'b1, 7'b0000000, 4'd10},  // R10
    '{8'h00, 1'b1, 1'b1, 3'b000, 1'b0, 1'b0, 7'b1000000, 4'd11},  // R11
    '{8'h82, 1'b0, 1'b1, 3'b001, 1'b0, 1'b0, 7'b1001000, 4'd12},  // R12
    '{8'h42, 1'b1, 1'b1, 3'b000, 1'b1, 1'b0, 7'b1011100, 4'd8 },  // R8
    '{8'h42, 1'b1, 1'b0, 3'b000, 1'b0, 1'b1, 7'b1011100, 4'd8 },  // R8 low read-only
    '{8'h42, 1'b1, 1'b1, 3'b001, 1'b0, 1'b1, 7'b1011001, 4'd8 },  // R8
    '{8'h03, 1'b1, 1'b1, 3'b001, 1'b0, 1'b1, 7'b1011100, 4'd3 },  // R3 lock kept, bank 3 ro
    '{8'h00, 1'b1, 1'b1, 3'b000, 1'b1, 1'b0, 7'b1011100, 4'd3 },  // R3
    '{8'hC0, 1'b1, 1'b0, 3'b000, 1'b0, 1'b1, 7'b1100010, 4'd5 },  // R5 force over lock
    '{8'h83, 1'b1, 1'b1, 3'b001, 1'b0, 1'b1, 7'b1011101, 4'd5 },  // R5
    '{8'h40, 1'b0, 1'b1, 3'b000, 1'b1, 1'b0, 7'b0001100, 4'd9 }   // R9
  };

  task automatic check(input string tag, input logic [6:0] exp);
    logic [6:0] act;
    act = {dis, rom_cs, ram_cs, bank, rom_we, ram_we};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] d);
    @(negedge clk);
    cfg_wr   = 1'b1;
    cfg_data = d;
    @(negedge clk);
    cfg_wr   = 1'b0;
    cfg_data = '0;
  endtask

  task automatic access(input logic m, input logic p, input logic [2:0] a,
                        input logic r, input logic w);
    mapped = m; wp = p; addr = a; rd = r; wr = w;
    #1;
  endtask

  task automatic pulse_por();
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); @(negedge clk); por_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    access(1'b0, 1'b1, 3'b000, 1'b1, 1'b0);
    check("R1 idle after power-on", 7'b0000000);
    access(1'b1, 1'b1, 3'b000, 1'b1, 1'b0);
    check("R1 rom after power-on", 7'b1100000);
    access(1'b1, 1'b1, 3'b001, 1'b1, 1'b0);
    check("R1 bank zero", 7'b1010000);

    for (int i = 0; i < NV; i++) begin
      cfg_write(VECS[i].cfg);
      access(VECS[i].map, VECS[i].wp, VECS[i].a, VECS[i].r, VECS[i].w);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].exp);
    end

    // R4: ordinary reset keeps the lock, clears force and bank
    cfg_write(8'hC2);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    access(1'b1, 1'b1, 3'b000, 1'b1, 1'b0);
    check("R4 lock survives reset", 7'b1011100);
    access(1'b1, 1'b1, 3'b001, 1'b1, 1'b0);
    check("R4 bank cleared", 7'b1010000);
    access(1'b0, 1'b1, 3'b000, 1'b1, 1'b0);
    check("R4 force cleared", 7'b0001100);

    // R1: power-on clears the lock
    pulse_por();
    access(1'b1, 1'b1, 3'b000, 1'b1, 1'b0);
    check("R1 lock cleared by power-on", 7'b1100000);

    // R2: write lands on the next edge
    @(negedge clk);
    cfg_wr = 1'b1; cfg_data = 8'h81;
    access(1'b0, 1'b1, 3'b000, 1'b1, 1'b0);
    check("R2 before edge", 7'b0000000);
    @(negedge clk);
    cfg_wr = 1'b0; cfg_data = '0;
    #1;
    check("R2 after edge", 7'b1100100);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule